// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets logic inside a synchronous chip read and write an external asynchronous static RAM of 512K bytes. The internal side is a single request line, with a write flag, an address and write data. The controller answers each request with a one-clock acknowledge, and for a read it returns the captured byte. On the memory side it drives a 19-bit address, two chip selects of opposite polarity, an active-low output enable and a read/write strobe that is high for read and low for write. It handles the 8-bit bidirectional data bus through separate out, drive-enable and in signals, which the pad ring joins.

Timing is set in nanoseconds by parameters: the clock period and the memory's read cycle, address access, output-enable access, write cycle, write pulse, select-to-end-of-write, data setup and bus release times. The controller rounds each of these up to whole clocks. The defaults suit a 100 MHz clock and the fast speed grade. A slower grade or a different clock needs only new parameter values. Between accesses the memory is kept deselected, which puts it in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, including the acknowledge cycle, the pins are sram_cs_n=1, sram_cs=0, sram_oe_n=1, sram_rw=1 and sram_dq_oe=0.
- R2: A read selects the memory with output enable low and sram_rw=1 for RD = ceil(max(read cycle, address access, output-enable access) / clock) clocks. Address and selects hold steady for that time. The byte on sram_dq_in at the last of those clocks is returned on rdata.
- R3: After a read the memory is deselected with output enable high for TURN = ceil(release time / clock) clocks (minimum 1) before the acknowledge. sram_dq_oe is never high while sram_oe_n is low.
- R4: A write drives the address, sram_rw=0 and the data for one clock with the memory still deselected, before both selects become active. sram_oe_n stays high during the whole write.
- R5: The write pulse keeps both selects active for WP = ceil(max(write pulse, select-to-end-of-write, data setup) / clock) clocks. Address and data are driven and steady during the pulse.
- R6: The selects are released while sram_rw is still low and data is still driven. This state lasts REC clocks, where REC = WC-1-WP if WC > WP+2, else 1, and WC = ceil(write cycle / clock). Then sram_rw returns high and the drive stops.
- R7: ack is high for exactly one clock. Counting from the clock edge that accepts the request, it rises RD+TURN edges later for a read and 1+WP+REC edges later for a write. req=1 with req_we=1 requests a write; req_we=0 requests a read.
- R8: A request raised while an access is in progress, or in the acknowledge cycle, is ignored. It produces no memory cycle, no acknowledge and no change to memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the access |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| sram_addr | output | 19 | Memory address pins |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_cs | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_rw | output | 1 | Read/write strobe, low writes |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | 8 | Data from the memory |

## Verification
The bench runs at 200 MHz, so with the default nanosecond values RD is 11, TURN 5, WP 10 and REC 1. A read's acknowledge is therefore due 17 sampling points after the request is raised, and a write's after 13. Each queued item carries the cycle count at which its request was raised, and the monitor compares the measured latency and the returned byte at the acknowledge. The memory model counts how long the read conditions have held and returns corrupted data until RD clocks have passed, so a capture made one clock early is visible. It also counts the select-active clocks of each write and commits the byte only when the pulse ends.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding, pin bundle and timing arithmetic for the
// asynchronous SRAM controller. Assumes all times are whole nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_REC   = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic sel_n;   // active-low select
        logic sel;     // active-high select
        logic oe_n;    // output enable, low = memory drives
        logic rw;      // 1 read, 0 write
        logic dq_oe;   // controller drives the data pads
    } pin_ctrl_t;

    localparam pin_ctrl_t PINS_STANDBY = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, rw: 1'b1, dq_oe: 1'b0};

    // Whole clocks needed to cover t_ns at a clock period of clk_ns.
    function automatic int unsigned clocks_for(input int unsigned t_ns, input int unsigned clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels that belong to each sequencer state.
    function automatic pin_ctrl_t pins_for(input seq_state_t st);
        pin_ctrl_t p;
        p = PINS_STANDBY;
        case (st)
            ST_RD_ACC: begin
                p.sel_n = 1'b0; p.sel = 1'b1; p.oe_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_REC: begin
                p.rw = 1'b0; p.dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                p.sel_n = 1'b0; p.sel = 1'b1; p.rw = 1'b0; p.dq_oe = 1'b1;
            end
            default: p = PINS_STANDBY;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Phase timer: a down-counter loaded at the start of each phase; 'last'
// marks the final clock of the phase. Assumes load values are count-1.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_req_latch.sv
`timescale 1ns/1ps
// Request latch: holds address and write data of the accepted request so
// they stay steady on the pins for the whole memory cycle.
module sram_req_latch #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    // Capture the request fields on the accepting edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Access sequencer: walks read and write phases, loads the phase timer,
// registers the memory control pins and the acknowledge. Assumes every
// phase count is at least 1.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned RD_CYC   = 6,
    parameter int unsigned TURN_CYC = 3,
    parameter int unsigned WP_CYC   = 5,
    parameter int unsigned REC_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             tmr_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             cap_en,
    output logic             ack,
    output pin_ctrl_t        pins
);
    seq_state_t st_q, st_nxt;
    logic       ack_q, ack_nxt;
    pin_ctrl_t  pins_q;

    // Next state, timer loads, capture strobe and completion.
    always_comb begin
        st_nxt   = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        cap_en   = 1'b0;
        ack_nxt  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req && !ack_q) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_we) begin
                        st_nxt  = ST_WR_SETUP;
                        tmr_val = '0;
                    end else begin
                        st_nxt  = ST_RD_ACC;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_last) begin
                    cap_en   = 1'b1;
                    st_nxt   = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (tmr_last) begin
                    st_nxt  = ST_IDLE;
                    ack_nxt = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_last) begin
                    st_nxt   = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    st_nxt   = ST_WR_REC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WR_REC: begin
                if (tmr_last) begin
                    st_nxt  = ST_IDLE;
                    ack_nxt = 1'b1;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State, acknowledge and glitch-free registered pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ack_q  <= 1'b0;
            pins_q <= PINS_STANDBY;
        end else begin
            st_q   <= st_nxt;
            ack_q  <= ack_nxt;
            pins_q <= pins_for(st_nxt);
        end
    end

    assign ack  = ack_q;
    assign pins = pins_q;
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Asynchronous SRAM controller top: converts nanosecond timing parameters
// into clock counts and ties the request latch, phase timer, sequencer and
// read capture register together. Assumes one access at a time and a pad
// ring that joins sram_dq_out/sram_dq_oe/sram_dq_in.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_RC_NS   = 55,
    parameter int unsigned T_AA_NS   = 55,
    parameter int unsigned T_OE_NS   = 30,
    parameter int unsigned T_REL_NS  = 25,
    parameter int unsigned T_WC_NS   = 55,
    parameter int unsigned T_WP_NS   = 45,
    parameter int unsigned T_CW_NS   = 50,
    parameter int unsigned T_DS_NS   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_cs,
    output logic              sram_oe_n,
    output logic              sram_rw,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int unsigned RD_CYC   = max_u(max_u(clocks_for(T_RC_NS, CLK_NS),
                                                   clocks_for(T_AA_NS, CLK_NS)),
                                             max_u(clocks_for(T_OE_NS, CLK_NS), 1));
    localparam int unsigned TURN_CYC = max_u(clocks_for(T_REL_NS, CLK_NS), 1);
    localparam int unsigned WP_CYC   = max_u(max_u(clocks_for(T_WP_NS, CLK_NS),
                                                   clocks_for(T_CW_NS, CLK_NS)),
                                             max_u(clocks_for(T_DS_NS, CLK_NS), 1));
    localparam int unsigned WC_CYC   = clocks_for(T_WC_NS, CLK_NS);
    localparam int unsigned REC_CYC  = (WC_CYC > WP_CYC + 2) ? (WC_CYC - 1 - WP_CYC) : 1;
    localparam int unsigned MAX_CYC  = max_u(max_u(RD_CYC, TURN_CYC), max_u(WP_CYC, REC_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    logic             accept;
    logic             cap_en;
    logic             tmr_load;
    logic             tmr_last;
    logic [CNT_W-1:0] tmr_val;
    pin_ctrl_t        pins;
    logic [DATA_W-1:0] rdata_q;

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .addr_q   (sram_addr),
        .wdata_q  (sram_dq_out)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .WP_CYC   (WP_CYC),
        .REC_CYC  (REC_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_we   (req_we),
        .tmr_last (tmr_last),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .accept   (accept),
        .cap_en   (cap_en),
        .ack      (ack),
        .pins     (pins)
    );

    // Read capture: sample the data pads on the last access clock.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (cap_en) rdata_q <= sram_dq_in;
    end

    assign rdata      = rdata_q;
    assign sram_cs_n  = pins.sel_n;
    assign sram_cs    = pins.sel;
    assign sram_oe_n  = pins.oe_n;
    assign sram_rw    = pins.rw;
    assign sram_dq_oe = pins.dq_oe;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the asynchronous SRAM controller, bound to the top.
// Observes only ports; all properties are gated by reset.
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ack,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_cs,
    input logic              sram_oe_n,
    input logic              sram_rw,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);
    AST_ACK_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (sram_cs_n && !sram_cs && sram_oe_n && sram_rw && !sram_dq_oe)); // R1

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n); // R3

    AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_rw |-> sram_oe_n); // R4

    AST_RW_BEFORE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sram_cs_n) && !sram_rw) |-> ($past(!sram_rw) && $stable(sram_addr))); // R4

    AST_WR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && !sram_rw) |-> (sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out))); // R5

    AST_RW_RISE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_rw) |-> (sram_cs_n && $past(sram_cs_n))); // R6

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R7

    AST_ACK_CYCLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> (sram_cs_n && sram_rw && !sram_dq_oe)); // R8
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ack         (ack),
    .sram_addr   (sram_addr),
    .sram_cs_n   (sram_cs_n),
    .sram_cs     (sram_cs),
    .sram_oe_n   (sram_oe_n),
    .sram_rw     (sram_rw),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver queues expected results, a negedge monitor
// compares them at each acknowledge, and a pin-level memory model checks
// access timing and stores written bytes.
module sram_async_ctrl_tb_top;
    localparam int CLK_NS = 5;
    localparam int E_RD   = 11;  // ceil(55/5)
    localparam int E_TURN = 5;   // ceil(25/5)
    localparam int E_WP   = 10;  // ceil(50/5)
    localparam int E_REC  = 1;   // WC=11 is not > WP+2
    localparam int LAT_RD = E_RD + E_TURN + 1;
    localparam int LAT_WR = 1 + E_WP + E_REC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [18:0] sram_addr;
    logic        sram_cs_n, sram_cs, sram_oe_n, sram_rw, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = '0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(.CLK_NS(CLK_NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_cs(sram_cs),
        .sram_oe_n(sram_oe_n), .sram_rw(sram_rw), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_issued = 0;
    int n_done = 0;

    typedef struct { bit is_rd; logic [18:0] addr; logic [7:0] data; int start; } item_t;
    item_t sb_q[$];

    logic [7:0] ref_mem [logic [18:0]];
    logic [7:0] mdl_mem [logic [18:0]];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_rd(input logic [18:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] mdl_rd(input logic [18:0] a);
        return mdl_mem.exists(a) ? mdl_mem[a] : 8'h00;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // R1: standby pin levels
    task automatic chk_standby(input string tag);
        chk({"R1 ", tag, " cs_n"}, sram_cs_n, 1);
        chk({"R1 ", tag, " cs"}, sram_cs, 0);
        chk({"R1 ", tag, " oe_n"}, sram_oe_n, 1);
        chk({"R1 ", tag, " rw"}, sram_rw, 1);
        chk({"R1 ", tag, " dq_oe"}, sram_dq_oe, 0);
    endtask

    // Memory model: read access counting, contention and write strobe checks.
    int          rd_run = 0;
    int          wr_run = 0;
    logic [18:0] rd_addr, wr_addr;
    logic [7:0]  wr_data;
    logic        prev_rw = 1'b1, prev_cs_n = 1'b1, prev_wsel = 1'b0;
    logic [18:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic sel   = !sram_cs_n && sram_cs;
            automatic logic rcond = sel && !sram_oe_n && sram_rw;
            automatic logic wsel  = sel && !sram_rw;
            if (rcond && rd_run > 0 && sram_addr == rd_addr) rd_run++;
            else if (rcond) begin rd_run = 1; rd_addr = sram_addr; end
            else rd_run = 0;
            sram_dq_in = (rcond && rd_run >= E_RD) ? mdl_rd(sram_addr) : ~mdl_rd(sram_addr);
            if (rcond && sram_dq_oe) chk("R3 bus driven during memory read", 1, 0);
            if (wsel && !prev_wsel) begin
                chk("R4 rw low while deselected before select", (!prev_rw && prev_cs_n) ? 1 : 0, 1);
                chk("R4 address set before select", sram_addr, prev_addr);
                wr_run = 0; wr_addr = sram_addr; wr_data = sram_dq_out;
            end
            if (wsel) begin
                wr_run++;
                if (sram_addr != wr_addr || sram_dq_out != wr_data || !sram_dq_oe || !sram_oe_n)
                    chk("R5 write pulse steady", 0, 1);
            end
            if (!wsel && prev_wsel) begin
                chk("R5 write pulse clocks", wr_run, E_WP);
                chk("R6 rw low and data driven at release", (!sram_rw && sram_dq_oe && sram_dq_out == wr_data) ? 1 : 0, 1);
                mdl_mem[wr_addr] = wr_data;
            end
            prev_rw = sram_rw; prev_cs_n = sram_cs_n; prev_wsel = wsel; prev_addr = sram_addr;
        end
    end

    // Monitor: pop the oldest expected item at each acknowledge.
    logic prev_ack = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ack) chk("R7 ack width one clock", ack, 0);
            if (ack) begin
                if (sb_q.size() == 0) begin
                    chk("R8 unexpected ack", 1, 0);
                end else begin
                    automatic item_t it = sb_q.pop_front();
                    chk(it.is_rd ? "R7 read latency" : "R7 write latency", cyc - it.start, it.is_rd ? LAT_RD : LAT_WR);
                    if (it.is_rd) chk("R2 read data", rdata, it.data);
                    chk_standby("at ack");
                end
                n_done++;
            end
            prev_ack = ack;
        end
    end

    // Driver: stray 0 none, 1 request while busy, 2 request in ack cycle.
    task automatic do_op(input bit is_rd, input logic [18:0] a, input logic [7:0] d,
                         input int stray, input logic [18:0] sa);
        automatic item_t it;
        @(negedge clk);
        req = 1'b1; req_we = !is_rd; req_addr = a; req_wdata = d;
        it.is_rd = is_rd; it.addr = a; it.start = cyc;
        if (is_rd) it.data = ref_rd(a);
        else begin it.data = d; ref_mem[a] = d; end
        sb_q.push_back(it);
        n_issued++;
        @(negedge clk);
        req = 1'b0;
        if (stray == 1) begin
            repeat (3) @(negedge clk);
            req = 1'b1; req_we = 1'b1; req_addr = sa; req_wdata = 8'hEE;
            @(negedge clk);
            req = 1'b0;
        end else if (stray == 2) begin
            forever begin
                @(negedge clk);
                if (ack) break;
            end
            req = 1'b1; req_we = 1'b1; req_addr = sa; req_wdata = 8'hDD;
            @(negedge clk);
            req = 1'b0;
        end
        wait (n_done == n_issued);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_standby("after reset");
        chk("R1 ack after reset", ack, 0);
        // R5 R6 writes, including the top address
        do_op(0, 19'h00000, 8'h3C, 0, '0);
        do_op(0, 19'h7FFFF, 8'hC3, 0, '0);
        do_op(0, 19'h12345, 8'h96, 0, '0);
        // R2 read back, plus a never-written address
        do_op(1, 19'h00000, 8'h00, 0, '0);
        do_op(1, 19'h7FFFF, 8'h00, 0, '0);
        do_op(1, 19'h12345, 8'h00, 0, '0);
        do_op(1, 19'h40000, 8'h00, 0, '0);
        // Mixed patterns: write then immediate read, read then immediate write (R3 turnaround)
        for (int i = 0; i < 8; i++) begin
            automatic logic [18:0] a = 19'(i * 19'h0A3B1 + 7);
            automatic logic [7:0]  d = 8'(i * 37) ^ 8'h5A;
            do_op(0, a, d, 0, '0);
            do_op(1, a, 8'h00, 0, '0);
            do_op(0, a ^ 19'h00001, ~d, 0, '0);
        end
        for (int i = 0; i < 8; i++) do_op(1, 19'(i * 19'h0A3B1 + 7) ^ 19'h00001, 8'h00, 0, '0);
        // R8: stray requests while busy and during the ack cycle are ignored
        do_op(1, 19'h12345, 8'h00, 1, 19'h00100);
        do_op(0, 19'h00200, 8'h11, 2, 19'h00300);
        do_op(1, 19'h00100, 8'h00, 0, '0);
        do_op(1, 19'h00300, 8'h00, 0, '0);
        do_op(1, 19'h00200, 8'h00, 0, '0);
        repeat (3) @(negedge clk);
        chk_standby("final idle");
        chk("R8 no outstanding items", sb_q.size(), 0);
        summary();
    end
endmodule